// File: doc/BRIEF.md
# Seconds/Minutes/Hours Timekeeper with Buffered Readout and Alarm

This block keeps time of day as three binary counters (seconds, minutes, hours) that advance by one second on each update cycle. An external one-pulse-per-second tick starts each update cycle. The block raises an update-in-progress flag, waits a fixed number of clock cycles, and then advances the internal counters. In the same cycle it copies the new time into a software-visible buffer and emits an update-ended pulse.

Software reaches the block through a small register port: an address, write data and a write strobe, with read data returned combinationally. Setting a hold bit stops the copy into the visible buffer, so software can write a new time at leisure; the internal counters keep counting meanwhile. Clearing the hold bit moves the written time into the internal counters.

Each update also compares the new internal time with three alarm bytes. A byte whose two top bits are both set matches any value. This widens the alarm to once per hour, once per minute or once per second.

Top module: `rtc_hms_update`

## Requirements
- R1: After reset every register (addresses 0 to 6) reads 0, and both `update_end_o` and `alarm_o` are low; an address of 7 reads 0.
- R2: A tick sampled while idle sets the update flag (bit 7 of the control register at address 6) from the next cycle for exactly LEAD_CYC cycles. At the end of that window the time advances by one second, the flag reads 0 again and `update_end_o` is high for one cycle. A tick sampled while the flag is 1 is ignored.
- R3: Counting is binary: seconds 0..59 carry into minutes 0..59, which carry into hours 0..23; 23:59:59 is followed by 00:00:00.
- R4: With the hold bit at 0, addresses 0 (seconds), 2 (minutes) and 4 (hours) read the new time from the cycle in which `update_end_o` is high.
- R5: With the hold bit (bit 0 of address 6) at 1, update cycles still run and still pulse `update_end_o`, but the time read at addresses 0, 2 and 4 changes only through register writes.
- R6: Writes to addresses 0, 2 and 4 set the visible time. Writing 0 to the hold bit while it is 1 loads the visible time into the internal counters in that cycle, so the next update shows that time plus one second.
- R7: While the update flag is 0, `update_end_o` is low in the following cycle.
- R8: `alarm_o` pulses in the same cycle as `update_end_o` when the new internal time equals the seconds, minutes and hours alarm bytes at addresses 1, 3 and 5; otherwise it stays low.
- R9: An alarm byte whose bits 7 and 6 are both 1 (0xC0 to 0xFF) matches any value. A byte with only one of those bits set is compared as a plain number. A wild hours byte alarms every hour, wild hours and minutes every minute, and all three wild every second.
- R10: The alarm compares the internal time, so it still fires while the hold bit is 1 and the visible time is frozen.
- R11: The alarm bytes read back as written. The control register reads the hold bit in bit 0 and the update flag in bit 7, with bits 6 to 1 reading 0. Writes to bits 7 to 1 of the control register have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse, once per second, that starts an update cycle |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| update_end_o | output | 1 | One-cycle pulse when an update cycle completes |
| alarm_o | output | 1 | One-cycle pulse when the new time matches the alarm bytes |

## Verification
A wrong internal counter cannot be seen at once while the hold bit is set. It shows either at the next alarm comparison, as a missing or extra `alarm_o` pulse, or in the visible time after the hold bit is cleared and one more update has run. A sequencer fault shows within one update cycle: the update flag reads wrong right after the tick, or `update_end_o` fires one or more cycles early or late. The bench therefore samples the flag immediately after each tick and checks the exact cycle of the pulse. It also uses alarms on the internal time to observe counting that the frozen buffer hides.

// File: rtl/rtc_hms_pkg.sv
package rtc_hms_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int N_FIELDS = 3;

    localparam logic [DATA_W-1:0] SEC_LAST = 8'd59;
    localparam logic [DATA_W-1:0] MIN_LAST = 8'd59;
    localparam logic [DATA_W-1:0] HR_LAST  = 8'd23;

    // packed so that bits [7:0] are seconds, matching field index 0
    typedef struct packed {
        logic [DATA_W-1:0] hr;
        logic [DATA_W-1:0] mn;
        logic [DATA_W-1:0] sc;
    } hms_t;

    typedef logic [N_FIELDS-1:0][DATA_W-1:0] field_vec_t;

    typedef enum logic [ADDR_W-1:0] {
        RA_SEC     = 3'd0,
        RA_SEC_ALM = 3'd1,
        RA_MIN     = 3'd2,
        RA_MIN_ALM = 3'd3,
        RA_HR      = 3'd4,
        RA_HR_ALM  = 3'd5,
        RA_CTRL    = 3'd6
    } reg_addr_e;

    localparam int CTRL_HOLD_BIT = 0;
    localparam int CTRL_BUSY_BIT = 7;

    function automatic hms_t hms_step(input hms_t t);
        hms_t r;
        r = t;
        if (t.sc >= SEC_LAST) begin
            r.sc = '0;
            if (t.mn >= MIN_LAST) begin
                r.mn = '0;
                if (t.hr >= HR_LAST) r.hr = '0;
                else                 r.hr = t.hr + 8'd1;
            end else begin
                r.mn = t.mn + 8'd1;
            end
        end else begin
            r.sc = t.sc + 8'd1;
        end
        return r;
    endfunction

    function automatic logic is_wild(input logic [DATA_W-1:0] a);
        return (a[DATA_W-1] & a[DATA_W-2]);
    endfunction

    function automatic logic field_hit(input logic [DATA_W-1:0] a,
                                       input logic [DATA_W-1:0] v);
        return is_wild(a) || (a == v);
    endfunction

endpackage

// File: rtl/rtc_upd_seq.sv
module rtc_upd_seq #(
    parameter int LEAD_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    output logic busy_o,
    output logic step_o
);
    localparam int CW = (LEAD_CYC > 2) ? $clog2(LEAD_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(LEAD_CYC - 1);

    logic          busy_q;
    logic [CW-1:0] cnt_q;

    assign busy_o = busy_q;
    assign step_o = busy_q && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!busy_q) begin
            if (tick_i) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
            end
        end else if (cnt_q == LAST) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |=> busy_q); // R2
    AST_TICK_STARTS: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && tick_i) |=> busy_q); // R2

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_hms_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step_i,
    input  logic load_i,
    input  hms_t load_val_i,
    output hms_t cur_o,
    output hms_t nxt_o
);
    hms_t cur_q;

    assign cur_o = cur_q;
    assign nxt_o = hms_step(cur_q);

    always_ff @(posedge clk) begin
        if (rst)         cur_q <= '0;
        else if (load_i) cur_q <= load_val_i;
        else if (step_i) cur_q <= nxt_o;
    end

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (cur_o == $past(load_val_i))); // R6
    AST_STEP_MOVES: assert property (@(posedge clk) disable iff (rst)
        (step_i && !load_i) |=> (cur_o != $past(cur_o))); // R3
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!step_i && !load_i) |=> $stable(cur_o)); // R2

endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
    import rtc_hms_pkg::*;
#(
    parameter int NF = N_FIELDS
) (
    input  logic [NF-1:0][DATA_W-1:0] time_i,
    input  logic [NF-1:0][DATA_W-1:0] alm_i,
    output logic                      hit_o
);
    logic [NF-1:0] fld_hit;

    for (genvar g = 0; g < NF; g++) begin : g_fld
        assign fld_hit[g] = field_hit(alm_i[g], time_i[g]);
    end

    assign hit_o = &fld_hit;

endmodule

// File: rtl/rtc_hms_update.sv
module rtc_hms_update
    import rtc_hms_pkg::*;
#(
    parameter int LEAD_CYC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wr_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              update_end_o,
    output logic              alarm_o
);
    logic       busy;
    logic       step;
    logic       load;
    logic       hit;
    hms_t       int_cur;
    hms_t       int_nxt;
    hms_t       vis_q;
    field_vec_t alm_q;
    field_vec_t nxt_f;
    logic       hold_q;
    logic       end_q;
    logic       alm_pulse_q;

    rtc_upd_seq #(.LEAD_CYC(LEAD_CYC)) i_seq (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_i),
        .busy_o (busy),
        .step_o (step)
    );

    assign load = wr_i && (addr_i == RA_CTRL) && !wdata_i[CTRL_HOLD_BIT] && hold_q;

    rtc_time_core i_core (
        .clk        (clk),
        .rst        (rst),
        .step_i     (step),
        .load_i     (load),
        .load_val_i (vis_q),
        .cur_o      (int_cur),
        .nxt_o      (int_nxt)
    );

    assign nxt_f = int_nxt;

    rtc_alarm_cmp #(.NF(N_FIELDS)) i_alm (
        .time_i (nxt_f),
        .alm_i  (alm_q),
        .hit_o  (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vis_q       <= '0;
            alm_q       <= '0;
            hold_q      <= 1'b0;
            end_q       <= 1'b0;
            alm_pulse_q <= 1'b0;
        end else begin
            end_q       <= step;
            alm_pulse_q <= step && !load && hit;
            if (step && !hold_q) vis_q <= int_nxt;
            if (wr_i) begin
                unique case (addr_i)
                    RA_SEC:     vis_q.sc <= wdata_i;
                    RA_MIN:     vis_q.mn <= wdata_i;
                    RA_HR:      vis_q.hr <= wdata_i;
                    RA_SEC_ALM: alm_q[0] <= wdata_i;
                    RA_MIN_ALM: alm_q[1] <= wdata_i;
                    RA_HR_ALM:  alm_q[2] <= wdata_i;
                    RA_CTRL:    hold_q   <= wdata_i[CTRL_HOLD_BIT];
                    default:    ;
                endcase
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            RA_SEC:     rdata_o = vis_q.sc;
            RA_MIN:     rdata_o = vis_q.mn;
            RA_HR:      rdata_o = vis_q.hr;
            RA_SEC_ALM: rdata_o = alm_q[0];
            RA_MIN_ALM: rdata_o = alm_q[1];
            RA_HR_ALM:  rdata_o = alm_q[2];
            RA_CTRL: begin
                rdata_o[CTRL_BUSY_BIT] = busy;
                rdata_o[CTRL_HOLD_BIT] = hold_q;
            end
            default:    rdata_o = '0;
        endcase
    end

    assign update_end_o = end_q;
    assign alarm_o      = alm_pulse_q;

    AST_END_SINGLE: assert property (@(posedge clk) disable iff (rst)
        update_end_o |=> !update_end_o); // R2
    AST_IDLE_NO_END: assert property (@(posedge clk) disable iff (rst)
        !busy |=> !update_end_o); // R7
    AST_ALARM_WITH_END: assert property (@(posedge clk) disable iff (rst)
        alarm_o |-> update_end_o); // R8
    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (rst)
        (hold_q && !wr_i) |=> $stable(vis_q)); // R5
    AST_VIS_TRACKS: assert property (@(posedge clk) disable iff (rst)
        (step && !hold_q && !wr_i) |=> (vis_q == int_cur)); // R4

endmodule

// File: tb/test_rtc_hms_update.sv
module test_rtc_hms_update;
    localparam int LEAD = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic [2:0] addr_i = '0;
    logic [7:0] wdata_i = '0;
    logic       wr_i = 1'b0;
    logic [7:0] rdata_o;
    logic       update_end_o;
    logic       alarm_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    rtc_hms_update #(.LEAD_CYC(LEAD)) i_rtc_hms_update (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick_i),
        .addr_i       (addr_i),
        .wdata_i      (wdata_i),
        .wr_i         (wr_i),
        .rdata_o      (rdata_o),
        .update_end_o (update_end_o),
        .alarm_o      (alarm_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr_i = a; wdata_i = d; wr_i = 1'b1;
        @(negedge clk);
        wr_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr_i = a;
        #1;
        d = rdata_o;
    endtask

    task automatic chk_reg(input logic [2:0] a, input logic [7:0] exp, input string req);
        logic [7:0] d;
        rd(a, d);
        chk(d == exp, req, d, exp);
    endtask

    task automatic chk_time(input int h, input int m, input int s, input string req);
        chk_reg(3'd0, 8'(s), req);
        chk_reg(3'd2, 8'(m), req);
        chk_reg(3'd4, 8'(h), req);
    endtask

    task automatic set_time(input int h, input int m, input int s);
        wr(3'd6, 8'h01);
        wr(3'd0, 8'(s));
        wr(3'd2, 8'(m));
        wr(3'd4, 8'(h));
        wr(3'd6, 8'h00);
    endtask

    task automatic set_alarm(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        wr(3'd1, s);
        wr(3'd3, m);
        wr(3'd5, h);
    endtask

    // one update cycle; checks flag timing, pulse cycle and alarm
    task automatic one_second(input bit exp_alarm, input bit dup, input string req);
        logic [7:0] d;
        @(negedge clk);
        rd(3'd6, d);
        chk(d[7] == 1'b0, "R7 flag idle before tick", d[7], 0);
        chk(update_end_o == 1'b0, "R7 no end while idle", update_end_o, 0);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        rd(3'd6, d);
        chk(d[7] == 1'b1, "R2 flag set after tick", d[7], 1);
        if (dup) begin
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
            chk(update_end_o == 1'b0, "R2 no early end", update_end_o, 0);
            repeat (LEAD - 2) @(posedge clk);
        end else begin
            repeat (LEAD - 1) @(posedge clk);
        end
        @(negedge clk);
        chk(update_end_o == 1'b0, "R2 end not early", update_end_o, 0);
        rd(3'd6, d);
        chk(d[7] == 1'b1, "R2 flag held full window", d[7], 1);
        @(negedge clk);
        chk(update_end_o == 1'b1, "R2 end pulse", update_end_o, 1);
        chk(alarm_o == exp_alarm, req, alarm_o, exp_alarm);
        rd(3'd6, d);
        chk(d[7] == 1'b0, "R2 flag clear after update", d[7], 0);
        @(negedge clk);
        chk(update_end_o == 1'b0, "R2 end single cycle", update_end_o, 0);
        chk(alarm_o == 1'b0, "R8 alarm single cycle", alarm_o, 0);
    endtask

    task automatic t_reset;
        for (int a = 0; a < 8; a++) chk_reg(3'(a), 8'h00, "R1 reset register");
        chk(update_end_o == 1'b0, "R1 reset end", update_end_o, 0);
        chk(alarm_o == 1'b0, "R1 reset alarm", alarm_o, 0);
    endtask

    task automatic t_count;
        set_alarm(8'h3F, 8'h3F, 8'h3F);
        chk_reg(3'd1, 8'h3F, "R11 alarm readback");
        chk_reg(3'd5, 8'h3F, "R11 alarm readback");
        one_second(1'b0, 1'b0, "R8 no alarm");
        chk_time(0, 0, 1, "R4 visible after update");
        set_time(0, 59, 58);
        chk_time(0, 59, 58, "R6 visible write");
        one_second(1'b0, 1'b0, "R8 no alarm");
        chk_time(0, 59, 59, "R3 seconds count");
        one_second(1'b0, 1'b0, "R8 no alarm");
        chk_time(1, 0, 0, "R3 minute and hour carry");
        set_time(23, 59, 59);
        one_second(1'b0, 1'b0, "R8 no alarm");
        chk_time(0, 0, 0, "R3 day wrap");
    endtask

    task automatic t_ignored_tick;
        one_second(1'b0, 1'b1, "R8 no alarm");
        chk_time(0, 0, 1, "R2 tick during update ignored");
    endtask

    task automatic t_hold;
        set_time(10, 20, 30);
        wr(3'd6, 8'h01);
        chk_reg(3'd6, 8'h01, "R11 hold readback");
        for (int i = 0; i < 3; i++) one_second(1'b0, 1'b0, "R5 no alarm");
        chk_time(10, 20, 30, "R5 visible frozen");
        wr(3'd0, 8'd5);
        wr(3'd2, 8'd6);
        wr(3'd4, 8'd7);
        chk_time(7, 6, 5, "R6 write under hold");
        wr(3'd6, 8'h00);
        chk_time(7, 6, 5, "R6 after release");
        one_second(1'b0, 1'b0, "R8 no alarm");
        chk_time(7, 6, 6, "R6 load then count");
    endtask

    task automatic t_hold_alarm;
        set_time(3, 0, 0);
        set_alarm(8'd3, 8'd0, 8'd2);
        wr(3'd6, 8'h01);
        one_second(1'b0, 1'b0, "R10 no alarm at 3:00:01");
        one_second(1'b1, 1'b0, "R10 alarm on internal time");
        chk_time(3, 0, 0, "R10 visible still frozen");
        wr(3'd6, 8'h00);
    endtask

    task automatic t_exact;
        set_alarm(8'd12, 8'd34, 8'd56);
        set_time(12, 34, 55);
        one_second(1'b1, 1'b0, "R8 exact match");
        one_second(1'b0, 1'b0, "R8 no match next second");
    endtask

    task automatic t_wild;
        set_alarm(8'hC0, 8'd0, 8'd0);
        set_time(5, 59, 58);
        one_second(1'b0, 1'b0, "R9 hourly not yet");
        one_second(1'b1, 1'b0, "R9 hourly fires");
        set_alarm(8'hC0, 8'hD5, 8'd30);
        set_time(17, 42, 29);
        one_second(1'b1, 1'b0, "R9 per minute fires");
        one_second(1'b0, 1'b0, "R9 per minute quiet");
        set_alarm(8'hFF, 8'hC0, 8'hE7);
        one_second(1'b1, 1'b0, "R9 every second");
        one_second(1'b1, 1'b0, "R9 every second");
        set_alarm(8'hFF, 8'hFF, 8'hBF);
        one_second(1'b0, 1'b0, "R9 bit7 alone is not wild");
        set_alarm(8'hFF, 8'hFF, 8'h7F);
        one_second(1'b0, 1'b0, "R9 bit6 alone is not wild");
    endtask

    task automatic t_ctrl;
        wr(3'd6, 8'hFE);
        chk_reg(3'd6, 8'h00, "R11 upper control bits ignored");
        wr(3'd6, 8'h81);
        chk_reg(3'd6, 8'h01, "R11 flag not writable");
        wr(3'd6, 8'h00);
        chk_reg(3'd6, 8'h00, "R11 hold cleared");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_count();
        t_ignored_tick();
        t_hold();
        t_hold_alarm();
        t_exact();
        t_wild();
        t_ctrl();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule